// File: doc/BRIEF.md
# Indirect Command-Word Register Bridge

This block lets a host reach the small 8-bit registers of a serial-bus controller core through one 64-bit command word. The host writes a word that carries a launch flag, a direction flag, a primary opcode, a secondary opcode and a data byte. The bridge decodes the target register, performs exactly one internal read, write or soft-reset access over a fixed number of cycles, and then clears the launch flag. For a read, the byte it fetches replaces the low byte of the same word. A host read of the port always returns the current word, so software polls the launch flag to see when the access is done.

The sequencer is a three-state machine. `ST_IDLE` waits for a launch. `IDLE->ISSUE` is taken when the host writes a word with the launch flag set. `ST_ISSUE` drives the core strobe for one cycle (`ISSUE->HOLD` always follows). `ST_HOLD` keeps the register select stable. It counts until the access window ends, and then takes `HOLD->IDLE`, completing the access on that edge. `HOLD->HOLD` is taken while the window is still open. The core is expected to present read data combinationally from the select lines.

Top module: `csr_core_bridge`

## Requirements
- R1: After reset, the host word reads all zeros, the core select is 0 and the strobes `core_wr`, `core_rd` and `core_rst` are low.
- R2: A host write with bit 63 set, taken at clock edge k while idle, reads back with bit 63 = 1 after edges k through k+ACCESS_CYCLES-1. Bit 63 reads back 0 after edge k+ACCESS_CYCLES (default ACCESS_CYCLES = 2).
- R3: When bit 56 = 0 and the target is a register, `core_wr` is high for exactly the one cycle after acceptance. During that cycle `core_sel` carries the target code and `core_wdata` carries bits 7:0.
- R4: Bits 60:57 give the primary opcode: 4 selects the clock high-period register (code 5). Primary opcode 6 uses bits 34:32: 1 selects data (code 1), 2 selects control (code 2), and 3 selects clock-control (code 3) on writes and status (code 4) on reads.
- R5: When bit 56 = 1 and the target is a register, `core_rd` pulses for one cycle. The byte on `core_rdata` at the final access cycle becomes bits 7:0 of the word when it completes. Bits 62:8 are unchanged and bit 63 is cleared.
- R6: Secondary opcode 7 under primary opcode 6 pulses `core_rst` for one cycle with no `core_wr` or `core_rd`. If bit 56 is set, bits 7:0 complete as zero.
- R7: Host writes made while an access is in flight are ignored. The word completes exactly as the launched command dictates, and no extra access is issued.
- R8: Any other opcode combination issues no strobe and keeps `core_sel` at 0. It completes with the same latency, and a read of it returns zero in bits 7:0.
- R9: A host write with bit 63 clear, made while idle, is stored and read back unchanged, and it starts no access.
- R10: At most one of `core_wr`, `core_rd` and `core_rst` is high in any cycle, and `core_sel` is 0 whenever no access is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe for the command word |
| host_wdata | input | 64 | Command word written by the host |
| host_rdata | output | 64 | Current command word as seen by the host |
| core_sel | output | 3 | Core register code: 0 none, 1 data, 2 control, 3 clock-control, 4 status, 5 high-period |
| core_wr | output | 1 | One-cycle write strobe to the core |
| core_rd | output | 1 | One-cycle read strobe to the core |
| core_wdata | output | 8 | Write byte for the core |
| core_rdata | input | 8 | Read byte from the core, valid while selected |
| core_rst | output | 1 | One-cycle soft-reset pulse to the core |

## Verification
The bench accepts a command at edge k. It expects the strobe in the cycle just after k, so the monitor samples it at the falling edge that follows. The busy flag is checked at each falling edge up to k+ACCESS_CYCLES-1, and the completed word and the idle select are checked at the falling edge after k+ACCESS_CYCLES. Every strobe is popped from a queue of expected core events. A strobe nobody queued, or a queued event that never appears by completion, counts as a failure. The test that writes during an access drives its word at edge k+1, which is inside the busy window.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

    localparam int WORD_W   = 64;
    localparam int BYTE_W   = 8;
    localparam int SEL_W    = 3;
    localparam int OP_W     = 4;
    localparam int XOP_W    = 3;

    // field positions inside the command word
    localparam int LAUNCH_BIT = 63;
    localparam int DIR_BIT    = 56;
    localparam int OP_LSB     = 57;
    localparam int XOP_LSB    = 32;

    // primary and secondary opcode values
    localparam logic [OP_W-1:0]  OPC_HIGHPER = 4'd4;
    localparam logic [OP_W-1:0]  OPC_EXTEND  = 4'd6;
    localparam logic [XOP_W-1:0] XOPC_DATA   = 3'd1;
    localparam logic [XOP_W-1:0] XOPC_CTRL   = 3'd2;
    localparam logic [XOP_W-1:0] XOPC_CLOCK  = 3'd3;
    localparam logic [XOP_W-1:0] XOPC_RESET  = 3'd7;

    // internal target codes; 1..5 are also the core select codes
    typedef enum logic [SEL_W-1:0] {
        TGT_NONE    = 3'd0,
        TGT_DATA    = 3'd1,
        TGT_CTRL    = 3'd2,
        TGT_CLKCTL  = 3'd3,
        TGT_STAT    = 3'd4,
        TGT_HIGHPER = 3'd5,
        TGT_RESET   = 3'd6
    } target_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_HOLD  = 2'd2
    } state_e;

endpackage

// File: rtl/bridge_cmd_decode.sv
module bridge_cmd_decode
    import bridge_pkg::*;
(
    input  logic [OP_W-1:0]  opcode,
    input  logic [XOP_W-1:0] xopcode,
    input  logic             is_read,
    output target_e          target,
    output logic             is_reg
);

    always_comb begin
        target = TGT_NONE;
        if (opcode == OPC_HIGHPER) begin
            target = TGT_HIGHPER;
        end else if (opcode == OPC_EXTEND) begin
            case (xopcode)
                XOPC_DATA:  target = TGT_DATA;
                XOPC_CTRL:  target = TGT_CTRL;
                XOPC_CLOCK: target = is_read ? TGT_STAT : TGT_CLKCTL;
                XOPC_RESET: target = TGT_RESET;
                default:    target = TGT_NONE;
            endcase
        end
    end

    always_comb begin
        unique case (target)
            TGT_DATA, TGT_CTRL, TGT_CLKCTL, TGT_STAT, TGT_HIGHPER: is_reg = 1'b1;
            default:                                               is_reg = 1'b0;
        endcase
    end

endmodule

// File: rtl/bridge_access_fsm.sv
module bridge_access_fsm
    import bridge_pkg::*;
#(
    parameter int ACCESS_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    output logic issue,
    output logic done,
    output logic busy
);

    localparam int LAST  = (ACCESS_CYCLES < 2) ? 1 : ACCESS_CYCLES - 1;
    localparam int CNT_W = $clog2(LAST + 1) + 1;

    state_e           state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             window_end;

    assign window_end = (cnt_q == CNT_W'(LAST));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (launch) state_d = ST_ISSUE;
            end
            ST_ISSUE: begin
                cnt_d   = CNT_W'(1);
                state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (window_end) begin
                    cnt_d   = '0;
                    state_d = ST_IDLE;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            default: begin
                cnt_d   = '0;
                state_d = ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        issue = 1'b0;
        done  = 1'b0;
        busy  = 1'b1;
        unique case (state_q)
            ST_IDLE:  busy  = 1'b0;
            ST_ISSUE: issue = 1'b1;
            ST_HOLD:  done  = window_end;
            default:  busy  = 1'b0;
        endcase
    end

    AST_ISSUE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_ISSUE |=> state_q == ST_HOLD); // R2
    AST_HOLD_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_HOLD |-> cnt_q <= CNT_W'(LAST)); // R2
    AST_DONE_RETURNS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R2

endmodule

// File: rtl/bridge_cmd_word.sv
module bridge_cmd_word
    import bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [WORD_W-1:0] host_wdata,
    input  logic              busy,
    input  logic              done,
    input  logic              is_read,
    input  logic              is_reg,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic [WORD_W-1:0] word_q,
    output logic              launch
);

    logic              accept;
    logic [BYTE_W-1:0] ret_byte;

    assign accept   = host_wr && !busy;
    assign launch   = accept && host_wdata[LAUNCH_BIT];
    assign ret_byte = is_reg ? rd_byte : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (accept) begin
            word_q <= host_wdata;
        end else if (done) begin
            word_q[LAUNCH_BIT] <= 1'b0;
            if (is_read) word_q[BYTE_W-1:0] <= ret_byte;
        end
    end

    AST_BUSY_HOLDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done |=> $stable(word_q)); // R7
    AST_DONE_CLEARS_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !word_q[LAUNCH_BIT]); // R2
    AST_DONE_KEEPS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> $stable(word_q[WORD_W-2:BYTE_W])); // R5
    AST_LAUNCH_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> word_q[LAUNCH_BIT]); // R2

endmodule

// File: rtl/csr_core_bridge.sv
module csr_core_bridge
    import bridge_pkg::*;
#(
    parameter int ACCESS_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    output logic [SEL_W-1:0]  core_sel,
    output logic              core_wr,
    output logic              core_rd,
    output logic [BYTE_W-1:0] core_wdata,
    input  logic [BYTE_W-1:0] core_rdata,
    output logic              core_rst
);

    logic [WORD_W-1:0] word_q;
    logic              launch, issue, done, busy;
    logic              is_read, is_reg;
    target_e           target;

    assign is_read = word_q[DIR_BIT];

    bridge_cmd_decode u_decode (
        .opcode  (word_q[OP_LSB +: OP_W]),
        .xopcode (word_q[XOP_LSB +: XOP_W]),
        .is_read (is_read),
        .target  (target),
        .is_reg  (is_reg)
    );

    bridge_access_fsm #(.ACCESS_CYCLES(ACCESS_CYCLES)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .launch (launch),
        .issue  (issue),
        .done   (done),
        .busy   (busy)
    );

    bridge_cmd_word u_word (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .busy       (busy),
        .done       (done),
        .is_read    (is_read),
        .is_reg     (is_reg),
        .rd_byte    (core_rdata),
        .word_q     (word_q),
        .launch     (launch)
    );

    assign host_rdata = word_q;
    assign core_sel   = (busy && is_reg) ? SEL_W'(target) : '0;
    assign core_wr    = issue && is_reg && !is_read;
    assign core_rd    = issue && is_reg && is_read;
    assign core_rst   = issue && (target == TGT_RESET);
    assign core_wdata = word_q[BYTE_W-1:0];

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({core_wr, core_rd, core_rst})); // R10
    AST_IDLE_SEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> core_sel == '0); // R10
    AST_UNDEF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        target == TGT_NONE |-> !core_wr && !core_rd && !core_rst && core_sel == '0); // R8
    AST_RST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst |=> !core_rst); // R6
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        core_wr || core_rd |=> !core_wr && !core_rd); // R3

endmodule

// File: tb/csr_core_bridge_tb.sv
module csr_core_bridge_tb;

    localparam int LAT = 2;
    localparam int EV_NONE = 0, EV_WR = 1, EV_RD = 2, EV_RST = 3;

    typedef struct {
        int         kind;
        logic [2:0] sel;
        logic [7:0] data;
        string      req;
    } ev_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [63:0] host_wdata = '0;
    logic [63:0] host_rdata;
    logic [2:0]  core_sel;
    logic        core_wr, core_rd, core_rst;
    logic [7:0]  core_wdata;
    logic [7:0]  core_rdata;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    ev_t exp_q[$];

    always #2 clk = ~clk;

    csr_core_bridge #(.ACCESS_CYCLES(LAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .core_sel(core_sel), .core_wr(core_wr),
        .core_rd(core_rd), .core_wdata(core_wdata), .core_rdata(core_rdata),
        .core_rst(core_rst)
    );

    // core register model: codes 1..5, status resets to F8
    logic [7:0] mdl [1:5];
    always_ff @(posedge clk) begin
        if (!rst_n || core_rst) begin
            mdl[1] <= 8'h00; mdl[2] <= 8'h00; mdl[3] <= 8'h00;
            mdl[4] <= 8'hF8; mdl[5] <= 8'h00;
        end else if (core_wr && core_sel >= 3'd1 && core_sel <= 3'd5) begin
            mdl[core_sel] <= core_wdata;
        end
    end
    assign core_rdata = (core_sel >= 3'd1 && core_sel <= 3'd5) ? mdl[core_sel] : 8'h00;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // monitor: every strobe must match the next queued event
    always @(negedge clk) begin
        if (rst_n && (core_wr || core_rd || core_rst)) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8 unexpected strobe", {57'd0, core_sel, core_wr, core_rd, core_rst}, 64'd0);
            end else begin
                ev_t e;
                int  k;
                e = exp_q.pop_front();
                k = core_wr ? EV_WR : (core_rd ? EV_RD : EV_RST);
                chk(k == e.kind, e.req, 64'(k), 64'(e.kind));
                chk($countones({core_wr, core_rd, core_rst}) == 1, "R10 strobe exclusivity",
                    64'({core_wr, core_rd, core_rst}), 64'd1);
                if (e.kind != EV_RST) chk(core_sel == e.sel, e.req, 64'(core_sel), 64'(e.sel));
                if (e.kind == EV_WR) chk(core_wdata == e.data, e.req, 64'(core_wdata), 64'(e.data));
            end
        end
    end

    function automatic logic [63:0] mk(input bit rd, input logic [3:0] op, input logic [2:0] xop,
                                        input logic [7:0] d);
        logic [63:0] w;
        w = '0;
        w[63] = 1'b1;
        w[60:57] = op;
        w[56] = rd;
        w[34:32] = xop;
        w[31:8] = 24'h5A_C3_19;
        w[7:0] = d;
        return w;
    endfunction

    task automatic run_cmd(input logic [63:0] w, input int kind, input logic [2:0] sel,
                           input logic [63:0] fin, input string req, input bit intrude);
        if (kind != EV_NONE) begin
            ev_t e;
            e.kind = kind; e.sel = sel; e.data = w[7:0]; e.req = req;
            exp_q.push_back(e);
        end
        @(negedge clk); host_wr = 1'b1; host_wdata = w;
        @(negedge clk); host_wr = 1'b0; host_wdata = '0;
        chk(host_rdata[63] == 1'b1, "R2 busy after accept", host_rdata, w);
        for (int i = 1; i < LAT; i++) begin
            if (intrude && i == 1) begin
                host_wr = 1'b1; host_wdata = mk(1'b0, 4'd6, 3'd1, 8'hEE);
            end
            @(negedge clk); host_wr = 1'b0; host_wdata = '0;
            chk(host_rdata[63] == 1'b1, "R2 still busy", host_rdata, 64'd1 << 63);
        end
        @(negedge clk);
        chk(host_rdata == fin, req, host_rdata, fin);
        chk(core_sel == 3'd0, "R10 idle select", 64'(core_sel), 64'd0);
        chk(exp_q.size() == 0, "R3 expected core event missing", 64'(exp_q.size()), 64'd0);
        exp_q.delete();
    endtask

    function automatic logic [63:0] wfin(input logic [63:0] w);
        return {1'b0, w[62:0]};
    endfunction

    function automatic logic [63:0] rfin(input logic [63:0] w, input logic [7:0] v);
        return {1'b0, w[62:8], v};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired", 64'd0, 64'd1);
        report();
    end

    initial begin
        logic [63:0] w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(host_rdata == '0, "R1 word after reset", host_rdata, 64'd0);
        chk(core_sel == 3'd0 && !core_wr && !core_rd && !core_rst, "R1 core outputs idle",
            {57'd0, core_sel, core_wr, core_rd, core_rst}, 64'd0);

        // R3 / R4: writes to each register
        w = mk(1'b0, 4'd6, 3'd1, 8'hA5); run_cmd(w, EV_WR, 3'd1, wfin(w), "R3 R4 write data", 1'b0);
        w = mk(1'b0, 4'd6, 3'd2, 8'h3C); run_cmd(w, EV_WR, 3'd2, wfin(w), "R3 R4 write control", 1'b0);
        w = mk(1'b0, 4'd6, 3'd3, 8'h5A); run_cmd(w, EV_WR, 3'd3, wfin(w), "R4 write clock-control", 1'b0);
        w = mk(1'b0, 4'd4, 3'd0, 8'h18); run_cmd(w, EV_WR, 3'd5, wfin(w), "R4 write high-period", 1'b0);

        // R5: reads
        w = mk(1'b1, 4'd6, 3'd1, 8'h77); run_cmd(w, EV_RD, 3'd1, rfin(w, 8'hA5), "R5 read data", 1'b0);
        w = mk(1'b1, 4'd6, 3'd2, 8'h00); run_cmd(w, EV_RD, 3'd2, rfin(w, 8'h3C), "R5 read control", 1'b0);
        w = mk(1'b1, 4'd6, 3'd3, 8'h11); run_cmd(w, EV_RD, 3'd4, rfin(w, 8'hF8), "R4 R5 read status", 1'b0);
        w = mk(1'b1, 4'd4, 3'd0, 8'h22); run_cmd(w, EV_RD, 3'd5, rfin(w, 8'h18), "R5 read high-period", 1'b0);

        // R6: soft reset
        w = mk(1'b0, 4'd6, 3'd7, 8'h33); run_cmd(w, EV_RST, 3'd0, wfin(w), "R6 soft reset", 1'b0);
        w = mk(1'b1, 4'd6, 3'd1, 8'h44); run_cmd(w, EV_RD, 3'd1, rfin(w, 8'h00), "R6 data cleared", 1'b0);
        w = mk(1'b1, 4'd6, 3'd7, 8'hFF); run_cmd(w, EV_RST, 3'd0, rfin(w, 8'h00), "R6 reset read zero", 1'b0);

        // R8: undefined combinations
        w = mk(1'b1, 4'd6, 3'd0, 8'h99); run_cmd(w, EV_NONE, 3'd0, rfin(w, 8'h00), "R8 undefined read", 1'b0);
        w = mk(1'b0, 4'd2, 3'd1, 8'h66); run_cmd(w, EV_NONE, 3'd0, wfin(w), "R8 undefined write", 1'b0);
        w = mk(1'b1, 4'd6, 3'd5, 8'h55); run_cmd(w, EV_NONE, 3'd0, rfin(w, 8'h00), "R8 undefined ext read", 1'b0);

        // R7: write during busy is ignored
        w = mk(1'b0, 4'd6, 3'd2, 8'h42); run_cmd(w, EV_WR, 3'd2, wfin(w), "R7 setup control", 1'b0);
        w = mk(1'b1, 4'd6, 3'd2, 8'h00); run_cmd(w, EV_RD, 3'd2, rfin(w, 8'h42), "R7 busy write ignored", 1'b1);
        w = mk(1'b1, 4'd6, 3'd1, 8'h00); run_cmd(w, EV_RD, 3'd1, rfin(w, 8'h00), "R7 data untouched", 1'b0);

        // R9: store without launch
        w = {1'b0, 63'h0C00_0001_1234_5678};
        @(negedge clk); host_wr = 1'b1; host_wdata = w;
        @(negedge clk); host_wr = 1'b0; host_wdata = '0;
        repeat (3) @(negedge clk);
        chk(host_rdata == w, "R9 stored word", host_rdata, w);
        chk(core_sel == 3'd0, "R9 no access", 64'(core_sel), 64'd0);

        repeat (2) @(negedge clk);
        report();
    end

endmodule